// File: doc/BRIEF.md
# Dual-Mode Baud Tick Generator

This block derives a 16x oversampling strobe for a serial port from a fast system clock. A single 16-bit baud value, written over a simple strobe-and-data port, is interpreted in one of two ways. A mode input selects which. In integer mode the value is a divide count: one tick is emitted each time that many clocks have elapsed. In fractional mode the value is an increment. It is added to a 16-bit phase accumulator every clock, and every carry out of the accumulator produces a tick. That gives fine rate resolution for fast bit rates, above roughly 19200 baud. Integer mode serves the slower rates. Software computes the value: divisor = f_clk / (16 * baud) for integer mode, and increment = baud * 16 * 2^16 / f_clk for fractional mode.

A three-state controller tracks what the generator is doing. `ST_IDLE` is entered whenever the run enable is low. `ST_DIV` is entered when running with the mode input low, and `ST_FRAC` when running with the mode input high. The controller moves between any two states on the clock edge where run enable or mode calls for a different state. Each such transition, and each write of the baud value, restarts the active engine from zero. The tick output is a one-clock pulse, registered, synchronous to the system clock.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the tick output is low, the generator is in `ST_IDLE`, and the baud value is 1.
- R2: In integer mode with a baud value N of 2 or more, a tick is output in clock k after a restart exactly when k is a multiple of N. Clock 1 is the first clock following the restart edge.
- R3: In integer mode a baud value of 0 or 1 gives a tick on every clock, and the generator never locks up.
- R4: In fractional mode with increment I, a tick is output in clock k after a restart exactly when floor(k*I/65536) exceeds floor((k-1)*I/65536). An increment of 0 never ticks.
- R5: While run enable is low, no tick is emitted on any clock following an edge at which run enable was sampled low.
- R6: A write of the baud value (`baud_we` high at an edge) loads the value. It also restarts the active counter or accumulator from zero, so the tick is low in the next clock.
- R7: A change of mode while running restarts the generator from zero under the new interpretation, and the tick is low in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Generator enable; low stops all ticks |
| frac_mode | input | 1 | 0 = integer divide, 1 = fractional accumulate |
| baud_we | input | 1 | Write strobe for the baud value |
| baud_wdata | input | BAUD_W | Baud value to load |
| tick_o | output | 1 | One-clock oversampling tick |

## Verification
The hardest situation to reach is a restart that lands in the middle of a period, while the counter or the accumulator holds a partial value. This includes a mode flip that reinterprets the same stored value. The stimulus rewrites the baud value a few clocks into an integer period. It flips the mode while an accumulator is part-filled, and it drops and raises run enable between two ticks. A behavioural model counts clocks since the last restart and compares its prediction with the tick on every clock, so a missing or stale restart shows up as a shifted tick.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_FRAC = 2'd2
    } gen_state_e;
endpackage

// File: rtl/baud_hold.sv
module baud_hold #(
    parameter int BAUD_W     = 16,
    parameter int RESET_BAUD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [BAUD_W-1:0] wdata,
    output logic [BAUD_W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  value <= BAUD_W'(RESET_BAUD);
        else if (we) value <= wdata;
    end
endmodule

// File: rtl/div_engine.sv
module div_engine #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [BAUD_W-1:0] divisor,
    output logic              tick
);
    logic [BAUD_W-1:0] cnt_q;
    logic [BAUD_W-1:0] limit;

    // divisors 0 and 1 both wrap every clock
    assign limit = (divisor <= BAUD_W'(1)) ? '0 : divisor - BAUD_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (clr || !en) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q >= limit) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + BAUD_W'(1);
            tick  <= 1'b0;
        end
    end

    // R2: with a divisor of two or more, ticks never fall on adjacent clocks
    assert_div_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && divisor > BAUD_W'(1)) |=> (!tick || !$stable(divisor)));
endmodule

// File: rtl/frac_engine.sv
module frac_engine #(
    parameter int BAUD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              clr,
    input  logic [BAUD_W-1:0] incr,
    output logic              tick
);
    localparam int SUM_W = BAUD_W + 1;

    logic [BAUD_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;

    assign sum = SUM_W'(acc_q) + SUM_W'(incr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (clr || !en) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else begin
            acc_q <= sum[BAUD_W-1:0];
            tick  <= sum[BAUD_W];
        end
    end

    // R4: a zero increment can never carry
    assert_frac_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (incr == '0) |=> !tick);
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int BAUD_W     = 16,
    parameter int RESET_BAUD = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              frac_mode,
    input  logic              baud_we,
    input  logic [BAUD_W-1:0] baud_wdata,
    output logic              tick_o
);
    import baudgen_pkg::*;

    gen_state_e        state_q, state_nx;
    logic              restart;
    logic              div_en, frac_en;
    logic              div_tick, frac_tick;
    logic [BAUD_W-1:0] baud_q;

    baud_hold #(.BAUD_W(BAUD_W), .RESET_BAUD(RESET_BAUD)) u_hold (
        .clk(clk), .rst_n(rst_n), .we(baud_we), .wdata(baud_wdata), .value(baud_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // transitions: any state goes to IDLE when stopped, else to the mode's state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run_en) state_nx = frac_mode ? ST_FRAC : ST_DIV;
            end
            ST_DIV: begin
                if (!run_en)        state_nx = ST_IDLE;
                else if (frac_mode) state_nx = ST_FRAC;
            end
            ST_FRAC: begin
                if (!run_en)         state_nx = ST_IDLE;
                else if (!frac_mode) state_nx = ST_DIV;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign restart = baud_we || (state_nx != state_q);

    // outputs: engine selection
    always_comb begin
        div_en  = 1'b0;
        frac_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DIV:  div_en  = 1'b1;
            ST_FRAC: frac_en = 1'b1;
            default: ;
        endcase
    end

    div_engine #(.BAUD_W(BAUD_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(div_en), .clr(restart),
        .divisor(baud_q), .tick(div_tick)
    );

    frac_engine #(.BAUD_W(BAUD_W)) u_frac (
        .clk(clk), .rst_n(rst_n), .en(frac_en), .clr(restart),
        .incr(baud_q), .tick(frac_tick)
    );

    assign tick_o = div_tick | frac_tick;

    assert_stopped_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !tick_o);

    assert_write_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        baud_we |=> !tick_o);

    assert_mode_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_nx != state_q) |=> !tick_o);

    assert_small_div_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && !restart && baud_q <= BAUD_W'(1)) |=> tick_o);

    assert_single_engine_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(div_tick && frac_tick));
endmodule

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         run_en = 1'b0;
    logic         frac_mode = 1'b0;
    logic         baud_we = 1'b0;
    logic [W-1:0] baud_wdata = '0;
    logic         tick_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string req = "R1";

    // reference model state
    int     m_state = 0;   // 0 idle, 1 divide, 2 fractional
    longint m_k = 0;
    longint m_baud = 1;
    logic   exp_tick = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    baud_tick_gen #(.BAUD_W(W), .RESET_BAUD(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .frac_mode(frac_mode),
        .baud_we(baud_we), .baud_wdata(baud_wdata), .tick_o(tick_o)
    );

    always @(posedge clk) begin
        int     nx;
        logic   clr;
        longint eff;
        if (!rst_n) begin
            m_state  = 0;
            m_k      = 0;
            m_baud   = 1;
            exp_tick = 1'b0;
        end else begin
            nx  = !run_en ? 0 : (frac_mode ? 2 : 1);
            clr = baud_we || (nx != m_state);
            if (clr || m_state == 0) begin
                m_k      = 0;
                exp_tick = 1'b0;
            end else begin
                m_k = m_k + 1;
                if (m_state == 1) begin
                    eff      = (m_baud <= 1) ? 1 : m_baud;
                    exp_tick = ((m_k % eff) == 0);
                end else begin
                    exp_tick = (((m_k * m_baud) >> 16) != (((m_k - 1) * m_baud) >> 16));
                end
            end
            m_state = nx;
            if (baud_we) m_baud = longint'(baud_wdata);
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            checks++;
            if (tick_o !== exp_tick) begin
                errors++;
                $display("FAIL %s cycle %0d: tick=%0b expected %0b", req, cyc, tick_o, exp_tick);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_baud(input logic [W-1:0] v);
        baud_wdata = v;
        baud_we    = 1'b1;
        @(negedge clk);
        baud_we    = 1'b0;
    endtask

    initial begin
        // R1: reset state, generator stopped
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(8);

        // R3: default value 1 in integer mode ticks every clock
        req = "R3";
        run_en = 1'b1;
        wait_cycles(10);

        // R2: divisor 5
        req = "R2";
        write_baud(16'd5);
        wait_cycles(40);

        // R6: rewrite in the middle of a period
        req = "R6";
        write_baud(16'd7);
        wait_cycles(3);
        write_baud(16'd4);
        wait_cycles(25);

        // R3: divisor 0 and 1
        req = "R3";
        write_baud(16'd0);
        wait_cycles(10);
        write_baud(16'd1);
        wait_cycles(10);

        // R4: fractional increments
        req = "R4";
        write_baud(16'h3000);
        frac_mode = 1'b1;
        wait_cycles(100);
        write_baud(16'hFFFF);
        wait_cycles(40);
        write_baud(16'd0);
        wait_cycles(20);
        write_baud(16'h1234);
        wait_cycles(200);

        // R7: flip mode with a part-filled accumulator, then back
        req = "R7";
        write_baud(16'd6);
        wait_cycles(5);
        frac_mode = 1'b0;
        wait_cycles(20);
        frac_mode = 1'b1;
        wait_cycles(30);
        frac_mode = 1'b0;
        wait_cycles(3);

        // R5: stop between ticks, stay stopped, restart
        req = "R5";
        run_en = 1'b0;
        wait_cycles(20);
        write_baud(16'd3);
        wait_cycles(5);
        run_en = 1'b1;
        wait_cycles(15);
        run_en = 1'b0;
        frac_mode = 1'b1;
        wait_cycles(10);

        // R1: reset in the middle of operation returns to idle
        req = "R1";
        run_en = 1'b1;
        wait_cycles(7);
        rst_n = 1'b0;
        wait_cycles(2);
        rst_n = 1'b1;
        run_en = 1'b0;
        wait_cycles(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule